// File: doc/BRIEF.md
# Boot Strap Capture and External Interrupt Front End

This block serves a set of shared external pins that change role at reset. While the synchronous hardware reset is held, the pins are boot straps. Their value at the final clock edge of reset is kept in an operating-mode register for the rest of the run. With four pins this gives one of sixteen boot modes.

Once reset is released, the same pins become active-low external interrupt requests. Each request passes through its own synchronizer chain. Each line can be set to level-sensitive or falling-edge detection, and each has its own pending flag, enable bit and acknowledge. Two registered wake outputs tell the core to leave its wait or stop low-power state. The wait wake is taken from enabled pending flags. The stop wake is also taken from the live synchronized low level of an enabled line, so a clock-gated core can be released even while a line is set to edge detection.

Top module: `strap_irq_ctrl`

## Requirements
- R1: `mode_o` bit i equals `pin_i` bit i as sampled at the last rising clock edge at which `rst` is high.
- R2: After reset is released, `mode_o` keeps its value whatever the pins do.
- R3: A pin change reaches `pend_o` at the third rising edge after it is applied. Two synchronizer edges come first and do not change `pend_o`.
- R4: With `cfg_edge_i` bit = 0 (level), `pend_o` for that line is 1 while the synchronized pin is low. It returns to 0, with the same latency, after the pin goes high.
- R5: With `cfg_edge_i` bit = 1 (falling edge), a 1-to-0 transition sets the pending bit. The bit stays set after the pin returns high. An `ack_i` pulse clears it at the next edge, but a new edge in the same cycle as the acknowledge wins.
- R6: In edge mode, a pin held low after its pending bit has been acknowledged does not set the bit again.
- R7: A line with `en_i` bit = 0 still shows its pending state on `pend_o` but never drives `wake_wait_o` or `wake_stop_o`.
- R8: `wake_wait_o` is 1 one edge after `in_wait_i` is 1 while any enabled line is pending. It is 0 one edge after `in_wait_i` drops.
- R9: `wake_stop_o` is 1 one edge after `in_stop_i` is 1 while any enabled line is pending or held low. This holds in edge mode too, so it is set on the same edge as `pend_o` and stays set after an acknowledge while the pin stays low.
- R10: While `rst` is high, `pend_o`, `wake_wait_o` and `wake_stop_o` are 0. A strap held low across reset release in edge mode does not create a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| pin_i | input | NLINES | Shared strap / active-low interrupt pins |
| cfg_edge_i | input | NLINES | Per line: 1 = falling edge, 0 = low level |
| en_i | input | NLINES | Per line interrupt enable (1 = unmasked) |
| ack_i | input | NLINES | Per line acknowledge pulse for edge pending bits |
| in_wait_i | input | 1 | Core is in the wait state |
| in_stop_i | input | 1 | Core is in the stop state |
| mode_o | output | NLINES | Captured boot mode |
| pend_o | output | NLINES | Per line pending flags |
| wake_wait_o | output | 1 | Release request for the wait state |
| wake_stop_o | output | 1 | Release request for the stop state |

## Verification
The assertions check on every cycle that the mode register never moves outside reset and that pending bits are clear just after a reset cycle. They also check that an edge pending bit persists until acknowledged, and that neither wake output fires without an enabled line or the matching low-power state. The exact pipeline latency, which edge a level or an edge is seen on, and the acknowledge-versus-new-edge collision can only be shown by the bench scenarios. The same goes for the absence of a spurious request from a strap held low across reset release, and the stop wake persisting after an acknowledge.

// File: rtl/strap_irq_pkg.sv
package strap_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // Free-running chain: it also tracks the straps during reset, so the
  // edge detector starts from the real pin level on release.
  always_ff @(posedge clk) begin
    chain_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_line.sv
module irq_line
  import strap_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_i,
  input  trig_e trig_i,
  input  logic  ack_i,
  output logic  pend_o,
  output logic  low_o
);
  logic sync_q;
  logic prev_q;
  logic fall;
  logic pend_q;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (pin_i),
    .q_o (sync_q)
  );

  always_ff @(posedge clk) begin
    prev_q <= sync_q;
  end

  assign fall = prev_q & ~sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (trig_i == TRIG_FALL) begin
      pend_q <= fall | (pend_q & ~ack_i);
    end else begin
      pend_q <= ~sync_q;
    end
  end

  assign pend_o = pend_q;
  assign low_o  = ~sync_q;

  // R10: nothing pending right after a reset cycle
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (pend_q == 1'b0));

  // R5: edge pending bit is sticky until acknowledged
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (trig_i == TRIG_FALL && pend_q && !ack_i) |=> pend_q);
endmodule

// File: rtl/mode_strap.sv
module mode_strap #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] mode_o
);
  logic [W-1:0] mode_q;

  // Loads every reset cycle; the last load before release is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= pin_i;
    end
  end

  assign mode_o = mode_q;

  // R2: boot mode frozen outside reset
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
endmodule

// File: rtl/strap_irq_ctrl.sv
module strap_irq_ctrl
  import strap_irq_pkg::*;
#(
  parameter int NLINES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pin_i,
  input  logic [NLINES-1:0] cfg_edge_i,
  input  logic [NLINES-1:0] en_i,
  input  logic [NLINES-1:0] ack_i,
  input  logic              in_wait_i,
  input  logic              in_stop_i,
  output logic [NLINES-1:0] mode_o,
  output logic [NLINES-1:0] pend_o,
  output logic              wake_wait_o,
  output logic              wake_stop_o
);
  localparam int MODE_W = NLINES;

  logic [NLINES-1:0] pend;
  logic [NLINES-1:0] low;
  logic              wait_hit;
  logic              stop_hit;
  logic              wake_wait_q;
  logic              wake_stop_q;

  mode_strap #(.W(MODE_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .mode_o (mode_o)
  );

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      irq_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i[i]),
        .trig_i (trig_e'(cfg_edge_i[i])),
        .ack_i  (ack_i[i]),
        .pend_o (pend[i]),
        .low_o  (low[i])
      );
    end
  endgenerate

  assign wait_hit = |(en_i & pend);
  assign stop_hit = |(en_i & (pend | low));

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_wait_q <= 1'b0;
      wake_stop_q <= 1'b0;
    end else begin
      wake_wait_q <= in_wait_i & wait_hit;
      wake_stop_q <= in_stop_i & stop_hit;
    end
  end

  assign pend_o      = pend;
  assign wake_wait_o = wake_wait_q;
  assign wake_stop_o = wake_stop_q;

  // R8: wait wake only when the core was waiting
  a_r8_wait_gate: assert property (@(posedge clk) disable iff (rst)
    wake_wait_q |-> $past(in_wait_i));

  // R7: no wake of either kind with every line disabled
  a_r7_masked_no_wake: assert property (@(posedge clk) disable iff (rst)
    (wake_wait_q || wake_stop_q) |-> $past(|en_i));

  // R9: stop wake only when the core was stopped
  a_r9_stop_gate: assert property (@(posedge clk) disable iff (rst)
    wake_stop_q |-> $past(in_stop_i));
endmodule

// File: tb/strap_irq_ctrl_tb.sv
module strap_irq_ctrl_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pin_i, cfg_edge_i, en_i, ack_i;
  logic         in_wait_i, in_stop_i;
  logic [N-1:0] mode_o, pend_o;
  logic         wake_wait_o, wake_stop_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  strap_irq_ctrl #(.NLINES(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .cfg_edge_i(cfg_edge_i),
    .en_i(en_i), .ack_i(ack_i), .in_wait_i(in_wait_i), .in_stop_i(in_stop_i),
    .mode_o(mode_o), .pend_o(pend_o), .wake_wait_o(wake_wait_o),
    .wake_stop_o(wake_stop_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_strap_and_reset();
    rst = 1'b1; pin_i = 4'b1010; cfg_edge_i = '1; en_i = '1; ack_i = '0;
    in_wait_i = 1'b1; in_stop_i = 1'b1;
    step(4);
    chk("R10 pend in reset", pend_o, 4'b0000);
    chk("R10 wake_wait in reset", wake_wait_o, 0);
    chk("R10 wake_stop in reset", wake_stop_o, 0);
    pin_i = 4'b0110;
    step(1);
    rst = 1'b0; pin_i = 4'b1111; in_wait_i = 1'b0; in_stop_i = 1'b0;
    step(1);
    chk("R1 mode capture", mode_o, 4'b0110);
    pin_i = 4'b1001;
    step(3);
    pin_i = 4'b1111;
    step(4);
    chk("R2 mode held", mode_o, 4'b0110);
    ack_i = '1; step(1); ack_i = '0; step(1);
  endtask

  task automatic t_level();
    cfg_edge_i = 4'b0000;
    pin_i[0] = 1'b0;
    step(2);
    chk("R3 not yet after two edges", pend_o[0], 0);
    step(1);
    chk("R3 R4 level pend on third edge", pend_o, 4'b0001);
    pin_i[0] = 1'b1;
    step(2);
    chk("R4 level still pending", pend_o[0], 1);
    step(1);
    chk("R4 level released", pend_o, 4'b0000);
  endtask

  task automatic t_edge();
    cfg_edge_i = 4'b1111;
    pin_i[1] = 1'b0;
    step(3);
    chk("R5 edge sets pend", pend_o, 4'b0010);
    pin_i[1] = 1'b1;
    step(3);
    chk("R5 sticky after pin high", pend_o[1], 1);
    ack_i[1] = 1'b1; step(1); ack_i[1] = 1'b0;
    chk("R5 ack clears", pend_o[1], 0);
    pin_i[1] = 1'b0;
    step(3);
    chk("R5 second edge", pend_o[1], 1);
    ack_i[1] = 1'b1; step(1); ack_i[1] = 1'b0;
    chk("R6 cleared with pin low", pend_o[1], 0);
    step(4);
    chk("R6 held low no retrigger", pend_o[1], 0);
    pin_i[1] = 1'b1;
    step(3);
    pin_i[2] = 1'b0;
    step(2);
    ack_i[2] = 1'b1; step(1); ack_i[2] = 1'b0;
    chk("R5 new edge beats ack", pend_o[2], 1);
    ack_i[2] = 1'b1; step(1); ack_i[2] = 1'b0;
    pin_i[2] = 1'b1;
    step(3);
    chk("R5 lines idle", pend_o, 4'b0000);
  endtask

  task automatic t_mask();
    cfg_edge_i = 4'b0000; en_i = 4'b1110; in_wait_i = 1'b1; in_stop_i = 1'b1;
    pin_i[0] = 1'b0;
    step(4);
    chk("R7 raw pend visible", pend_o[0], 1);
    chk("R7 masked no wait wake", wake_wait_o, 0);
    chk("R7 masked no stop wake", wake_stop_o, 0);
    pin_i[0] = 1'b1;
    step(3);
    en_i = 4'b1111; in_wait_i = 1'b0; in_stop_i = 1'b0;
    step(1);
  endtask

  task automatic t_wait();
    cfg_edge_i = 4'b1111; in_wait_i = 1'b1;
    pin_i[3] = 1'b0;
    step(3);
    chk("R8 pend set", pend_o[3], 1);
    chk("R8 wake one edge later", wake_wait_o, 0);
    step(1);
    chk("R8 wake_wait", wake_wait_o, 1);
    chk("R8 no stop wake", wake_stop_o, 0);
    in_wait_i = 1'b0;
    step(1);
    chk("R8 wake drops with wait", wake_wait_o, 0);
    ack_i[3] = 1'b1; step(1); ack_i[3] = 1'b0;
    pin_i[3] = 1'b1;
    step(3);
  endtask

  task automatic t_stop();
    cfg_edge_i = 4'b1111; in_stop_i = 1'b1;
    pin_i[2] = 1'b0;
    step(2);
    chk("R9 stop wake not yet", wake_stop_o, 0);
    step(1);
    chk("R9 stop wake with pend", wake_stop_o, 1);
    ack_i[2] = 1'b1; step(1); ack_i[2] = 1'b0;
    step(1);
    chk("R9 pend acked", pend_o[2], 0);
    chk("R9 level keeps stop wake", wake_stop_o, 1);
    pin_i[2] = 1'b1;
    step(3);
    chk("R9 stop wake released", wake_stop_o, 0);
    in_stop_i = 1'b0;
    step(1);
  endtask

  task automatic t_strap_low_release();
    rst = 1'b1; cfg_edge_i = 4'b1111; pin_i = 4'b0000;
    step(4);
    rst = 1'b0;
    step(6);
    chk("R1 low strap mode", mode_o, 4'b0000);
    chk("R10 no spurious edge", pend_o, 4'b0000);
    pin_i = 4'b1111;
    step(3);
  endtask

  initial begin
    t_strap_and_reset();
    t_level();
    t_edge();
    t_mask();
    t_wait();
    t_stop();
    t_strap_low_release();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule